// File: doc/BRIEF.md
# Switchable Victim Selection Unit for a Four-Way Cache

This unit decides which way of a set a four-way, 64-set cache should evict. The surrounding cache reports every access to it as an event carrying a set index, a way and a flag that says whether the way was just filled or was hit. The cache asks for a victim by putting a set index on a query input, and the unit answers combinationally from its stored history.

A three-bit mode input chooses the eviction rule. The rules are oldest fill, newest fill, least recently touched, most recently touched, least often used, and a pseudo-random pick. All six rules read one shared body of state per set: a fill-order ranking, a recency ranking and a 4-bit use counter for each way. One free-running shift register supplies the random picks. The mode may change at any time. Because the history is always kept up to date, a new rule takes effect at once and needs no warm-up. Tags, data and valid bits stay in the cache.

Top module: `repl_policy_unit`

## Requirements
- R1: After reset, every set reports way 0 as victim in modes 0, 2 and 4 and way 3 in modes 1 and 3. The fill order and the recency order both start with way 0 oldest and way 3 newest, and every use counter starts at zero.
- R2: Mode 0 (oldest fill) evicts the way of the set that was filled earliest. Hit events do not change this choice.
- R3: Mode 1 (newest fill) evicts the way of the set that was filled most recently. Hit events do not change this choice.
- R4: Mode 2 (least recent) evicts the way whose last fill or hit is oldest. A touched way becomes the newest, and only the ways that were newer than it move one step older.
- R5: Mode 3 (most recent) evicts the way whose last fill or hit in that set is the latest.
- R6: Mode 4 (least used) evicts the way with the smallest 4-bit counter, and a tie goes to the lowest way number. A fill sets the counter of that way to 1. A hit adds 1 and holds the counter at 15.
- R7: Mode 5 (random) returns bits [1:0] of a 16-bit shift register. The register loads 0xACE1 at reset and shifts left on every clock. The new bit 0 is the XOR of bits 15, 13, 12 and 10. Events do not affect it.
- R8: An event changes only the set it names, and only in a cycle where its valid input is high. A victim answer reflects events up to the previous clock edge.
- R9: Mode codes 6 and 7 act exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Eviction rule select (0 oldest fill, 1 newest fill, 2 least recent, 3 most recent, 4 least used, 5 random) |
| evt_valid_i | input | 1 | Access event present this cycle |
| evt_fill_i | input | 1 | 1 = event is a fill, 0 = event is a hit |
| evt_set_i | input | 6 | Set index of the event |
| evt_way_i | input | 2 | Way of the event |
| query_set_i | input | 6 | Set whose victim is requested |
| victim_o | output | 2 | Way to evict from the queried set |

## Verification
A corrupted ranking in this block does not show up right away. It stays hidden until a query reads the affected set in a mode that consults that ranking, and then it shows as a wrong victim in that same cycle. For this reason the bench drives fill and hit sequences whose victims differ under each rule, and it queries both the touched set and an untouched set. A counter that wraps instead of saturating only becomes visible after sixteen hits. A misrouted event only becomes visible when a neighbouring set is read. The bench forces both of these cases.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [2:0] {
    MODE_OLD_FILL = 3'd0,
    MODE_NEW_FILL = 3'd1,
    MODE_LEAST_REC = 3'd2,
    MODE_MOST_REC = 3'd3,
    MODE_LEAST_USE = 3'd4,
    MODE_RANDOM   = 3'd5
  } repl_mode_e;
endpackage

// File: rtl/repl_rank_tbl.sv
// Per-set permutation of ages, 0 = oldest, WAYS-1 = newest.
module repl_rank_tbl #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [SW-1:0] set_i,
  input  logic [WW-1:0] way_i,
  input  logic [SW-1:0] rd_set_i,
  output logic [WW-1:0] oldest_o,
  output logic [WW-1:0] newest_o
);
  logic [WW-1:0] rank_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= WW'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == way_i)
          rank_q[set_i][w] <= WW'(WAYS - 1);
        else if (rank_q[set_i][w] > rank_q[set_i][way_i])
          rank_q[set_i][w] <= rank_q[set_i][w] - 1'b1;
      end
    end
  end

  always_comb begin
    oldest_o = '0;
    newest_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rank_q[rd_set_i][w] == '0) oldest_o = WW'(w);
      if (rank_q[rd_set_i][w] == WW'(WAYS - 1)) newest_o = WW'(w);
    end
  end
endmodule

// File: rtl/repl_lfu_tbl.sv
module repl_lfu_tbl #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  parameter int CNT_W = 4,
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS),
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          fill_i,
  input  logic [SW-1:0] set_i,
  input  logic [WW-1:0] way_i,
  input  logic [SW-1:0] rd_set_i,
  output logic [WW-1:0] victim_o
);
  logic [CNT_W-1:0] cnt_q [SETS][WAYS];
  logic [CNT_W-1:0] best_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          cnt_q[s][w] <= '0;
    end else if (upd_i) begin
      if (fill_i)
        cnt_q[set_i][way_i] <= CNT_W'(1);
      else if (cnt_q[set_i][way_i] != CNT_MAX)
        cnt_q[set_i][way_i] <= cnt_q[set_i][way_i] + 1'b1;
    end
  end

  // strict compare keeps the lowest way on ties
  always_comb begin
    victim_o = '0;
    best_cnt = cnt_q[rd_set_i][0];
    for (int w = 1; w < WAYS; w++) begin
      if (cnt_q[rd_set_i][w] < best_cnt) begin
        best_cnt = cnt_q[rd_set_i][w];
        victim_o = WW'(w);
      end
    end
  end
endmodule

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter int W = 16,
  parameter int OUT_W = 2,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign rnd_o = q[OUT_W-1:0];
endmodule

// File: rtl/repl_policy_unit.sv
module repl_policy_unit
  import repl_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             evt_valid_i,
  input  logic             evt_fill_i,
  input  logic [SET_W-1:0] evt_set_i,
  input  logic [WAY_W-1:0] evt_way_i,
  input  logic [SET_W-1:0] query_set_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] fill_old, fill_new, rec_old, rec_new, lfu_vic, rnd_vic;

  repl_rank_tbl #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_fill_ord (
    .clk_i, .rst_ni,
    .touch_i(evt_valid_i & evt_fill_i),
    .set_i(evt_set_i), .way_i(evt_way_i), .rd_set_i(query_set_i),
    .oldest_o(fill_old), .newest_o(fill_new)
  );

  repl_rank_tbl #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_recency (
    .clk_i, .rst_ni,
    .touch_i(evt_valid_i),
    .set_i(evt_set_i), .way_i(evt_way_i), .rd_set_i(query_set_i),
    .oldest_o(rec_old), .newest_o(rec_new)
  );

  repl_lfu_tbl #(.SETS(NUM_SETS), .WAYS(NUM_WAYS), .CNT_W(CNT_W)) u_use_cnt (
    .clk_i, .rst_ni,
    .upd_i(evt_valid_i), .fill_i(evt_fill_i),
    .set_i(evt_set_i), .way_i(evt_way_i), .rd_set_i(query_set_i),
    .victim_o(lfu_vic)
  );

  repl_lfsr #(.OUT_W(WAY_W)) u_rnd (
    .clk_i, .rst_ni, .rnd_o(rnd_vic)
  );

  always_comb begin
    unique case (repl_mode_e'(mode_i))
      MODE_NEW_FILL:  victim_o = fill_new;
      MODE_LEAST_REC: victim_o = rec_old;
      MODE_MOST_REC:  victim_o = rec_new;
      MODE_LEAST_USE: victim_o = lfu_vic;
      MODE_RANDOM:    victim_o = rnd_vic;
      default:        victim_o = fill_old; // codes 0, 6, 7
    endcase
  end
endmodule

// File: rtl/repl_policy_chk.sv
module repl_policy_chk #(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic             evt_valid_i,
  input logic             evt_fill_i,
  input logic [SET_W-1:0] evt_set_i,
  input logic [WAY_W-1:0] evt_way_i,
  input logic [SET_W-1:0] query_set_i,
  input logic [WAY_W-1:0] victim_o
);
  logic             ev_q, fill_q;
  logic [SET_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= 1'b0; fill_q <= 1'b0; set_q <= '0; way_q <= '0;
    end else begin
      ev_q <= evt_valid_i; fill_q <= evt_fill_i; set_q <= evt_set_i; way_q <= evt_way_i;
    end
  end

  logic hit_set;
  assign hit_set = ev_q && (set_q == query_set_i);

  assert_old_fill_not_new_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_set && fill_q && mode_i == 3'd0) |-> victim_o != way_q);

  assert_new_fill_is_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_set && fill_q && mode_i == 3'd1) |-> victim_o == way_q);

  assert_least_rec_not_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_set && mode_i == 3'd2) |-> victim_o != way_q);

  assert_most_rec_is_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_set && mode_i == 3'd3) |-> victim_o == way_q);

  assert_quiet_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_q && $stable(query_set_i) && $stable(mode_i) && mode_i != 3'd5) |-> $stable(victim_o));
endmodule

bind repl_policy_unit repl_policy_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .evt_valid_i(evt_valid_i),
  .evt_fill_i(evt_fill_i), .evt_set_i(evt_set_i), .evt_way_i(evt_way_i),
  .query_set_i(query_set_i), .victim_o(victim_o)
);

// File: tb/sim_repl_policy_unit.sv
`timescale 1ns/1ps
module sim_repl_policy_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       ev = 1'b0, fl = 1'b0;
  logic [5:0] es = '0, qs = '0;
  logic [1:0] ew = '0;
  logic [1:0] victim;

  int n_total = 0, n_fail = 0;
  bit done = 1'b0;
  logic [1:0] exp_q [$];
  string      tag_q [$];
  logic [15:0] rnd_m;

  always #4 clk = ~clk;

  repl_policy_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .evt_valid_i(ev), .evt_fill_i(fl),
    .evt_set_i(es), .evt_way_i(ew), .query_set_i(qs), .victim_o(victim)
  );

  // R7 model from the stated polynomial and seed
  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) rnd_m <= 16'hACE1;
    else         rnd_m <= {rnd_m[14:0], rnd_m[15] ^ rnd_m[13] ^ rnd_m[12] ^ rnd_m[10]};

  task automatic expect_v(input logic [2:0] m, input logic [5:0] s, input logic [1:0] e, input string t);
    @(negedge clk);
    mode = m; qs = s;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic expect_rnd(input logic [5:0] s, input string t);
    @(negedge clk);
    mode = 3'd5; qs = s;
    exp_q.push_back(rnd_m[1:0]); tag_q.push_back(t);
  endtask

  task automatic send_evt(input bit f, input logic [5:0] s, input logic [1:0] w);
    @(negedge clk);
    ev = 1'b1; fl = f; es = s; ew = w;
    @(negedge clk);
    ev = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        automatic logic [1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        n_total++;
        if (victim !== e) begin
          n_fail++;
          $display("FAIL %s: victim=%0d expected=%0d", t, victim, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin : driver
    #30 rst_ni = 1'b1;
    // R1 reset state
    expect_v(3'd0, 6'd0, 2'd0, "R1 old-fill reset");
    expect_v(3'd1, 6'd0, 2'd3, "R1 new-fill reset");
    expect_v(3'd2, 6'd0, 2'd0, "R1 least-rec reset");
    expect_v(3'd3, 6'd0, 2'd3, "R1 most-rec reset");
    expect_v(3'd4, 6'd0, 2'd0, "R1 least-use reset");
    expect_v(3'd3, 6'd63, 2'd3, "R1 most-rec reset set 63");
    // fills on set 5 in order 2,0,3,1
    send_evt(1, 6'd5, 2'd2);
    send_evt(1, 6'd5, 2'd0);
    send_evt(1, 6'd5, 2'd3);
    send_evt(1, 6'd5, 2'd1);
    expect_v(3'd0, 6'd5, 2'd2, "R2 oldest fill");
    expect_v(3'd1, 6'd5, 2'd1, "R3 newest fill");
    expect_v(3'd2, 6'd5, 2'd2, "R4 least recent after fills");
    expect_v(3'd4, 6'd5, 2'd0, "R6 tie to lowest way");
    // hits 2,2,0
    send_evt(0, 6'd5, 2'd2);
    send_evt(0, 6'd5, 2'd2);
    send_evt(0, 6'd5, 2'd0);
    expect_v(3'd0, 6'd5, 2'd2, "R2 hits ignored");
    expect_v(3'd1, 6'd5, 2'd1, "R3 hits ignored");
    expect_v(3'd2, 6'd5, 2'd3, "R4 least recent after hits");
    expect_v(3'd3, 6'd5, 2'd0, "R5 most recent hit");
    expect_v(3'd4, 6'd5, 2'd1, "R6 lowest count");
    // R8 neighbour set untouched, invalid events ignored
    expect_v(3'd0, 6'd6, 2'd0, "R8 other set old-fill");
    expect_v(3'd3, 6'd6, 2'd3, "R8 other set most-rec");
    @(negedge clk);
    ev = 1'b0; fl = 1'b1; es = 6'd5; ew = 2'd2;
    repeat (3) @(negedge clk);
    expect_v(3'd1, 6'd5, 2'd1, "R8 invalid fill ignored");
    expect_v(3'd3, 6'd5, 2'd0, "R8 invalid event no recency");
    // R6 saturation: 16 hits on way 3, then 3 hits on way 1
    for (int i = 0; i < 16; i++) send_evt(0, 6'd5, 2'd3);
    for (int i = 0; i < 3; i++) send_evt(0, 6'd5, 2'd1);
    expect_v(3'd4, 6'd5, 2'd0, "R6 counter saturates at 15");
    expect_v(3'd2, 6'd5, 2'd2, "R4 only newer ways age");
    expect_v(3'd3, 6'd5, 2'd1, "R5 most recent after hits");
    // fill resets counter
    send_evt(1, 6'd5, 2'd3);
    expect_v(3'd4, 6'd5, 2'd3, "R6 fill sets count to 1");
    expect_v(3'd0, 6'd5, 2'd2, "R2 oldest after refill");
    expect_v(3'd1, 6'd5, 2'd3, "R3 newest after refill");
    // R9 reserved codes
    expect_v(3'd6, 6'd5, 2'd2, "R9 code 6 as old-fill");
    expect_v(3'd7, 6'd5, 2'd2, "R9 code 7 as old-fill");
    // R7 random
    for (int i = 0; i < 6; i++) expect_rnd(6'd5, "R7 random pick");
    send_evt(0, 6'd9, 2'd1);
    for (int i = 0; i < 4; i++) expect_rnd(6'd9, "R7 random unaffected by events");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule